// File: doc/BRIEF.md
# UTOPIA Transmit Cell Receiver

This block is the PHY-side end of a UTOPIA transmit link. An ATM layer device writes cells to it one word per interface clock. Each cell is marked by a start-of-cell flag on its first word, and an active-low write enable qualifies every word. The block frames the words into cells and places each finished cell in a four-cell FIFO. A downstream reader drains that FIFO one word at a time.

A cell-available output tells the ATM layer whether another whole cell will fit. The output is computed from the committed cells plus the cell now being written. The ATM layer can therefore poll it near the end of the current cell and decide whether to start the next one.

Static mode inputs select the bus width, the cell size and single-PHY or multi-PHY operation. In multi-PHY mode the block answers only to its own address.

Top module: `utx_cell_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `clav_o` and `clav_oe_o` are 1 and `cell_rdy_o` is 0.
- R2: Words per cell follow the mode inputs. `cell_size_i` 00 gives 52 bytes, 01 gives 53, and 10 or 11 give 54. With `bus_width_i` = 01 the bus is 16 bits and a cell is ceil(bytes/2) words. Any other width value selects an 8-bit bus: a cell is one word per byte, and only `data_i[7:0]` is stored, zero-extended to 16 bits.
- R3: A word is taken on a rising clock edge only while `enb_ni` is 0. Cycles with `enb_ni` high change nothing, whatever `soc_i` and `data_i` hold.
- R4: A cell becomes readable only in the cycle after its last word is taken. A partly written cell never raises `cell_rdy_o`.
- R5: A taken word with `soc_i` = 1 always starts a new cell at word 0. Any partial cell is dropped.
- R6: Taken words with `soc_i` = 0 while no cell is open are ignored.
- R7: The FIFO holds at most four committed cells. A cell whose first word arrives while four cells are stored is discarded in full.
- R8: `clav_o` is 1 exactly when the committed cells plus the cell in progress number fewer than four.
- R9: With `multi_phy_i` = 0, `clav_oe_o` is always 1. With `multi_phy_i` = 1, `clav_oe_o` is 1 only while `addr_i` equals `phy_addr_i`, and words are taken only under that match.
- R10: A cycle with `rd_en_i` = 1 and `cell_rdy_o` = 1 pops one word. Cells come out in arrival order, words within a cell in write order, and `rd_sof_o` is 1 on word 0 of each cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| multi_phy_i | input | 1 | 1 selects multi-PHY addressing |
| bus_width_i | input | 2 | 01 selects the 16-bit bus; other values select the 8-bit bus |
| cell_size_i | input | 2 | Cell length select: 52, 53 or 54 bytes |
| phy_addr_i | input | 5 | Own PHY address used in multi-PHY mode |
| addr_i | input | 5 | Address driven by the ATM layer |
| enb_ni | input | 1 | Write enable, active low |
| soc_i | input | 1 | Start-of-cell flag, high with word 0 |
| data_i | input | 16 | Write data |
| clav_o | output | 1 | Room for a further full cell |
| clav_oe_o | output | 1 | Drive enable for `clav_o` |
| rd_en_i | input | 1 | Pop one word from the FIFO |
| rd_data_o | output | 16 | Word at the FIFO head |
| rd_sof_o | output | 1 | Head word is word 0 of a cell |
| cell_rdy_o | output | 1 | At least one full cell is stored |

## Verification
The assertions check the following on every cycle:
- the stored cell count never goes above four and changes by at most one per cycle;
- `clav_o` is low whenever the FIFO is full;
- the output enable is always on in single-PHY mode, and an unselected address freezes the framing position;
- an accepted start flag always lands the framer on word 1;
- an idle cycle with no start flag never opens a cell.

The bench scenarios cover what a single-cycle property cannot:
- the word count and narrow-bus data packing of every size and width setting;
- that data comes back intact and in order;
- that a fifth cell is really lost when four are stored;
- that `clav_o` drops as soon as the fourth cell opens;
- that enable-high cycles carrying a start flag leave a cell intact.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int MAX_CELL_WORDS = 54;

  function automatic logic [5:0] words_per_cell(input logic [1:0] width,
                                                input logic [1:0] size);
    logic [5:0] bytes;
    unique case (size)
      2'b00:   bytes = 6'd52;
      2'b01:   bytes = 6'd53;
      default: bytes = 6'd54;
    endcase
    if (width == 2'b01) return 6'((bytes + 6'd1) >> 1);
    return bytes;
  endfunction
endpackage

// File: rtl/utx_clav.sv
module utx_clav #(
  parameter int CELLS  = 4,
  parameter int CNT_W  = 3,
  parameter int ADDR_W = 5
) (
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic              enb_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              in_prog_i,
  output logic              clav_o,
  output logic              clav_oe_o,
  output logic              word_o
);
  logic sel;

  assign sel       = !multi_i || (addr_i == phy_addr_i);
  assign clav_oe_o = sel;
  assign word_o    = sel && !enb_ni;
  // room for a further cell once the open one is counted
  assign clav_o    = (int'(cnt_i) + int'(in_prog_i)) < CELLS;
endmodule

// File: rtl/utx_framer.sv
module utx_framer #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_i,
  input  logic              soc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wide_i,
  input  logic [IDX_W-1:0]  words_i,
  input  logic              space_ok_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o,
  output logic              active_o,
  output logic              keep_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int HALF_W = DATA_W / 2;

  logic             active_q, keep_q, keep_n;
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             start, cont, last;

  always_comb begin
    start   = word_i && soc_i;
    cont    = word_i && !soc_i && active_q;
    cur_idx = start ? '0 : idx_q;
    last    = (start || cont) && (cur_idx == words_i - 1'b1);
    keep_n  = start ? space_ok_i : keep_q;
  end

  assign wr_en_o   = (start || cont) && keep_n;
  assign wr_idx_o  = cur_idx;
  assign commit_o  = last && keep_n;
  assign wr_data_o = wide_i ? data_i : {{(DATA_W - HALF_W){1'b0}}, data_i[HALF_W-1:0]};
  assign active_o  = active_q;
  assign keep_o    = keep_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
      idx_q    <= '0;
    end else if (start || cont) begin
      keep_q <= keep_n;
      if (last) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        active_q <= 1'b1;
        idx_q    <= cur_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo #(
  parameter int CELLS     = 4,
  parameter int MAX_WORDS = 54,
  parameter int IDX_W     = 6,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = $clog2(CELLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  words_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sof_o,
  output logic              cell_rdy_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              space_ok_o
);
  localparam int SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int AW     = $clog2(CELLS * MAX_WORDS);

  logic [DATA_W-1:0] mem [CELLS*MAX_WORDS];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [IDX_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  cnt;
  logic              pop, release_cell;
  logic [AW-1:0]     wr_addr, rd_addr;

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return (int'(s) == CELLS - 1) ? '0 : s + 1'b1;
  endfunction

  assign wr_addr      = AW'(wr_slot) * AW'(MAX_WORDS) + AW'(wr_idx_i);
  assign rd_addr      = AW'(rd_slot) * AW'(MAX_WORDS) + AW'(rd_idx);
  assign cell_rdy_o   = (cnt != '0);
  assign pop          = rd_en_i && cell_rdy_o;
  assign release_cell = pop && (rd_idx == words_i - 1'b1);
  assign rd_data_o    = mem[rd_addr];
  assign rd_sof_o     = cell_rdy_o && (rd_idx == '0);
  assign cnt_o        = cnt;
  assign space_ok_o   = (cnt < CNT_W'(CELLS));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_slot <= '0;
      rd_slot <= '0;
      rd_idx  <= '0;
      cnt     <= '0;
    end else begin
      if (commit_i) wr_slot <= slot_inc(wr_slot);
      if (pop) begin
        if (release_cell) begin
          rd_idx  <= '0;
          rd_slot <= slot_inc(rd_slot);
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
      case ({commit_i, release_cell})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/utx_cell_rx.sv
module utx_cell_rx #(
  parameter int CELLS     = 4,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 5,
  parameter int MAX_WORDS = utx_pkg::MAX_CELL_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              multi_phy_i,
  input  logic [1:0]        bus_width_i,
  input  logic [1:0]        cell_size_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              enb_ni,
  input  logic              soc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              clav_o,
  output logic              clav_oe_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_sof_o,
  output logic              cell_rdy_o
);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam int CNT_W = $clog2(CELLS + 1);

  logic              word, wide, space_ok;
  logic              wr_en, commit;
  logic              frm_active, frm_keep;
  logic [IDX_W-1:0]  frm_idx, wr_idx, words;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  cell_cnt;

  assign wide  = (bus_width_i == 2'b01);
  assign words = IDX_W'(utx_pkg::words_per_cell(bus_width_i, cell_size_i));

  utx_clav #(.CELLS(CELLS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_clav (
    .multi_i    (multi_phy_i),
    .addr_i     (addr_i),
    .phy_addr_i (phy_addr_i),
    .enb_ni     (enb_ni),
    .cnt_i      (cell_cnt),
    .in_prog_i  (frm_active && frm_keep),
    .clav_o     (clav_o),
    .clav_oe_o  (clav_oe_o),
    .word_o     (word)
  );

  utx_framer #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .soc_i      (soc_i),
    .data_i     (data_i),
    .wide_i     (wide),
    .words_i    (words),
    .space_ok_i (space_ok),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .commit_o   (commit),
    .active_o   (frm_active),
    .keep_o     (frm_keep),
    .idx_o      (frm_idx)
  );

  utx_cell_fifo #(.CELLS(CELLS), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W),
                  .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .commit_i   (commit),
    .words_i    (words),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .rd_sof_o   (rd_sof_o),
    .cell_rdy_o (cell_rdy_o),
    .cnt_o      (cell_cnt),
    .space_ok_o (space_ok)
  );
endmodule

// File: rtl/utx_cell_rx_chk.sv
module utx_cell_rx_chk #(
  parameter int CELLS  = 4,
  parameter int CNT_W  = 3,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              multi_phy_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] phy_addr_i,
  input logic              enb_ni,
  input logic              soc_i,
  input logic              clav_o,
  input logic              clav_oe_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic              active_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_i) <= CELLS); // R7
  AST_CLAV_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt_i) == CELLS) |-> !clav_o); // R8
  AST_SINGLE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !multi_phy_i |-> clav_oe_o); // R9
  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (multi_phy_i && addr_i != phy_addr_i) |=> $stable(idx_i)); // R9
  AST_SOC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enb_ni && soc_i && clav_oe_o) |=> (active_i && idx_i == IDX_W'(1))); // R5
  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !soc_i) |=> !active_i); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + 1'b1) ||
    (cnt_i + 1'b1 == $past(cnt_i))); // R10
endmodule

bind utx_cell_rx utx_cell_rx_chk #(
  .CELLS(CELLS), .CNT_W(CNT_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .multi_phy_i (multi_phy_i),
  .addr_i      (addr_i),
  .phy_addr_i  (phy_addr_i),
  .enb_ni      (enb_ni),
  .soc_i       (soc_i),
  .clav_o      (clav_o),
  .clav_oe_o   (clav_oe_o),
  .cnt_i       (cell_cnt),
  .idx_i       (frm_idx),
  .active_i    (frm_active)
);

// File: tb/utx_cell_rx_bench.sv
module utx_cell_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        multi_phy_i = 1'b0;
  logic [1:0]  bus_width_i = 2'b01;
  logic [1:0]  cell_size_i = 2'b10;
  logic [4:0]  phy_addr_i = 5'd5;
  logic [4:0]  addr_i = 5'd0;
  logic        enb_ni = 1'b1;
  logic        soc_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        rd_en_i = 1'b0;
  logic        clav_o, clav_oe_o, rd_sof_o, cell_rdy_o;
  logic [15:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {bus_width, cell_size, expected words}
  localparam logic [9:0] VEC [7] = '{
    {2'b01, 2'b10, 6'd27}, {2'b01, 2'b01, 6'd27}, {2'b01, 2'b00, 6'd26},
    {2'b01, 2'b11, 6'd27}, {2'b00, 2'b10, 6'd54}, {2'b10, 2'b00, 6'd52},
    {2'b11, 2'b01, 6'd53}
  };

  always #10 clk_i = ~clk_i;

  utx_cell_rx u_utx_cell_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .multi_phy_i(multi_phy_i),
    .bus_width_i(bus_width_i), .cell_size_i(cell_size_i),
    .phy_addr_i(phy_addr_i), .addr_i(addr_i), .enb_ni(enb_ni),
    .soc_i(soc_i), .data_i(data_i), .clav_o(clav_o), .clav_oe_o(clav_oe_o),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_sof_o(rd_sof_o),
    .cell_rdy_o(cell_rdy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic [15:0] d);
    @(negedge clk_i);
    enb_ni = 1'b0; soc_i = s; data_i = d;
  endtask

  // enable high with a start flag and junk data: must be ignored
  task automatic gap();
    @(negedge clk_i);
    enb_ni = 1'b1; soc_i = 1'b1; data_i = 16'hDEAD;
  endtask

  task automatic send_cell(input logic [7:0] tag, input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      put(i == 0, {tag, 8'(i)});
      if (gaps) gap();
    end
    gap();
  endtask

  task automatic read_cell(input string req, input logic [7:0] tag, input int n, input bit narrow);
    logic [15:0] bad_act, bad_exp;
    bit bad, sof_bad;
    bad = 0; sof_bad = 0; bad_act = '0; bad_exp = '0;
    for (int i = 0; i < n; i++) begin
      logic [15:0] exp;
      @(negedge clk_i);
      exp = narrow ? {8'h00, 8'(i)} : {tag, 8'(i)};
      if (!bad && (rd_data_o !== exp || cell_rdy_o !== 1'b1)) begin
        bad = 1; bad_act = rd_data_o; bad_exp = exp;
      end
      if (rd_sof_o !== (i == 0)) sof_bad = 1;
      rd_en_i = 1'b1;
    end
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk({req, " data"}, bad ? bad_act : 32'h0, bad ? bad_exp : 32'h0);
    chk("R10 sof on word 0 only", sof_bad, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 clav in reset", clav_o, 1'b1);
    chk("R1 rdy in reset", cell_rdy_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 clav after reset", clav_o, 1'b1);
    chk("R1 oe after reset", clav_oe_o, 1'b1);
    chk("R1 rdy after reset", cell_rdy_o, 1'b0);

    // R2 / R4 table: words per cell for each width and size
    foreach (VEC[e]) begin
      int n;
      bus_width_i = VEC[e][9:8];
      cell_size_i = VEC[e][7:6];
      n = int'(VEC[e][5:0]);
      for (int i = 0; i < n - 1; i++) put(i == 0, {8'h30 + 8'(e), 8'(i)});
      gap();
      chk("R4 partial cell hidden", cell_rdy_o, 1'b0);
      put(1'b0, {8'h30 + 8'(e), 8'(n - 1)});
      gap();
      chk("R2 cell complete at word count", cell_rdy_o, 1'b1);
      read_cell("R2 table", 8'h30 + 8'(e), n, VEC[e][9:8] != 2'b01);
      chk("R10 fifo empty after read", cell_rdy_o, 1'b0);
    end

    bus_width_i = 2'b01;
    cell_size_i = 2'b10;

    // R7 / R8: fill four cells, fifth dropped
    for (int c = 1; c <= 3; c++) send_cell(8'(c), 27, 0);
    chk("R8 clav with three stored", clav_o, 1'b1);
    put(1'b1, {8'h04, 8'h00});
    gap();
    chk("R8 clav low with fourth open", clav_o, 1'b0);
    for (int i = 1; i < 27; i++) put(1'b0, {8'h04, 8'(i)});
    gap();
    chk("R8 clav low when full", clav_o, 1'b0);
    send_cell(8'h05, 27, 0);
    for (int c = 1; c <= 4; c++) read_cell("R7 order", 8'(c), 27, 0);
    chk("R7 fifth cell discarded", cell_rdy_o, 1'b0);
    chk("R8 clav back after drain", clav_o, 1'b1);

    // R5: start flag mid-cell
    for (int i = 0; i < 10; i++) put(i == 0, {8'hA0, 8'(i)});
    send_cell(8'hB0, 27, 0);
    chk("R5 restarted cell stored", cell_rdy_o, 1'b1);
    read_cell("R5 restart", 8'hB0, 27, 0);
    chk("R5 partial cell gone", cell_rdy_o, 1'b0);

    // R6: words with no open cell
    for (int i = 0; i < 27; i++) put(1'b0, {8'hC0, 8'(i)});
    gap();
    chk("R6 stray words ignored", cell_rdy_o, 1'b0);

    // R3: enable-high cycles between words
    send_cell(8'hD0, 27, 1);
    chk("R3 gapped cell stored", cell_rdy_o, 1'b1);
    read_cell("R3 gapped", 8'hD0, 27, 0);

    // R9: multi-PHY addressing
    multi_phy_i = 1'b1;
    addr_i = 5'd3;
    @(negedge clk_i);
    chk("R9 oe off when unselected", clav_oe_o, 1'b0);
    send_cell(8'h77, 27, 0);
    chk("R9 unselected writes ignored", cell_rdy_o, 1'b0);
    addr_i = 5'd5;
    @(negedge clk_i);
    chk("R9 oe on when selected", clav_oe_o, 1'b1);
    send_cell(8'h78, 27, 0);
    chk("R9 selected cell stored", cell_rdy_o, 1'b1);
    read_cell("R9 selected", 8'h78, 27, 0);
    multi_phy_i = 1'b0;
    addr_i = 5'd0;
    @(negedge clk_i);
    chk("R9 oe on in single mode", clav_oe_o, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule